// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the pin timing of the external memory bus for a small 8-bit controller core. A machine cycle lasts twelve oscillator clocks, split into six states of two phases. Each machine cycle is either a code cycle, which holds two opcode fetch slots (one per half), or a data cycle, which carries one external read or write. In a code cycle each half picks internal or external memory from the external-access input and the fetch address. An external half shows its address on the buses and pulses the program store strobe. An internal half leaves both strobes idle.

The low byte bus is shared: it carries the low address while the latch enable pulses, then the data byte. The high byte bus carries the upper address, or the port 2 latch value when no upper address is needed. Data requests come from the core with a plain valid/accept handshake and are taken only on the last clock of a machine cycle. The reset input passes through a filter, so the sequencer resets only after the input has stayed high for two whole machine cycles.

The cycle state machine has four states. CYC_RESET is held while the filtered reset is active. On the last clock of any cycle the machine always chooses the next state from the same rule. The transition *take_read* goes to CYC_DREAD when a read request is accepted. The transition *take_write* goes to CYC_DWRITE when a write request is accepted. The transition *fetch* goes to CYC_CODE when no request is pending. Leaving reset follows *fetch* or one of the take transitions.

Top module: `xbus_sequencer`

## Requirements
- R1: In a code cycle, `ale` is high for clock offsets 0–1 and 6–7 of the twelve-clock machine cycle, which gives two pulses per cycle.
- R2: In a data cycle, `ale` is high only at offsets 0–1, so the second pulse is dropped. `psen_n` stays high for the whole data cycle, so both fetch strobes are dropped.
- R3: For an external fetch half, `psen_n` is low at half offsets 3–5. For an internal half it stays high. `rd_n` and `wr_n` stay high in code cycles.
- R4: A fetch half is external when `ext_access` is 0, or when the fetch address is above 0x0FFF. The address is taken from `pc` on the clock that starts each half, at offsets 11 and 5.
- R5: During offsets 0–2 of an external half, and of a data cycle, `bus_lo_oe` is 1 and `bus_lo_out` holds the low address byte. For an internal half `bus_lo_oe` is 0.
- R6: `bus_hi` carries the upper fetch address in an external half, and the upper data address in a data access with `req_wide`=1. In an internal half, and in a data access with `req_wide`=0, it carries `p2_latch`.
- R7: In a read cycle, `rd_n` is low at offsets 4–9 and `bus_lo_oe` is 0 from offset 3 onward. `bus_lo_in` is sampled at the end of offset 9 and presented on `rdata`, with `rdata_valid` high for offset 10 only.
- R8: In a write cycle, `wr_n` is low at offsets 4–9. `bus_lo_oe` stays 1 for the whole cycle, and `bus_lo_out` holds the write byte from offset 3 to 11, so it is stable across the strobe.
- R9: `req_ack` is high only at offset 11 while `req_valid` is 1. An accepted request makes the next machine cycle a data cycle (read when `req_write`=0). Without one, the next cycle is a code cycle.
- R10: `core_rst` goes high only after `rst_in` has been high for 24 consecutive clocks. A shorter pulse has no effect and the bus keeps running.
- R11: While the sequencer is in reset, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1 and `bus_lo_oe`=0. The first clock after release is offset 0 of a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset, active high, filtered |
| pc | input | 16 | Program counter for the next fetch half |
| ext_access | input | 1 | 1 lets low addresses fetch internally |
| req_valid | input | 1 | Data access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | Request accepted this clock |
| p2_latch | input | 8 | Port 2 latch contents |
| bus_lo_in | input | 8 | Low byte bus, pin input |
| bus_lo_out | output | 8 | Low byte bus, pin output |
| bus_lo_oe | output | 1 | Low byte bus output enable |
| bus_hi | output | 8 | High byte bus |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Byte returned by a read |
| rdata_valid | output | 1 | `rdata` valid, one clock |
| core_rst | output | 1 | Filtered reset |

## Verification
The bench builds the block with its default parameters: two phases per state, six states, a 16-bit address, an 8-bit data bus, a 0x0FFF internal code top and a two-cycle reset hold. With these values a fetch pair starting at 0x0FFF puts one half on each side of the boundary inside a single machine cycle. The 24-clock reset threshold is also short enough that both 23-clock and 24-clock pulses fit in the run. Every clock of every vector cycle is compared against pin values derived from the offsets above.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    typedef enum logic [1:0] {
        CYC_RESET  = 2'd0,
        CYC_CODE   = 2'd1,
        CYC_DREAD  = 2'd2,
        CYC_DWRITE = 2'd3
    } cyc_kind_e;
endpackage

// File: rtl/xbus_rst_filter.sv
`timescale 1ns/1ps
// Passes reset through only after it has stayed high for HOLD_CLKS clocks.
module xbus_rst_filter #(
    parameter int HOLD_CLKS = 24
) (
    input  logic clk,
    input  logic rst_in,
    output logic core_rst
);
    localparam int CW = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_CLKS);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_in) begin
            hold_cnt <= '0;
        end else if (hold_cnt != FULL) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign core_rst = rst_in && (hold_cnt == FULL);
endmodule

// File: rtl/xbus_timebase.sv
`timescale 1ns/1ps
// Oscillator clock offset within the machine cycle.
module xbus_timebase #(
    parameter int TICKS = 12,
    localparam int TW = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          core_rst,
    output logic [TW-1:0] tick,
    output logic          cyc_last
);
    localparam logic [TW-1:0] LAST_T = TW'(TICKS - 1);

    always_ff @(posedge clk) begin
        if (core_rst) begin
            tick <= LAST_T;
        end else if (tick == LAST_T) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    assign cyc_last = (tick == LAST_T);
endmodule

// File: rtl/xbus_cycle_fsm.sv
`timescale 1ns/1ps
// Machine cycle kind, request capture, fetch selection and read capture.
module xbus_cycle_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TICKS  = 12,
    parameter int PHASES = 2,
    parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h0FFF,
    localparam int TW = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              core_rst,
    input  logic [TW-1:0]     tick,
    input  logic              cyc_last,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ext_access,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_lo_in,
    output cyc_kind_e         kind,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ext,
    output logic [ADDR_W-1:0] dat_addr,
    output logic              dat_wide,
    output logic [DATA_W-1:0] dat_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    localparam logic [TW-1:0] HALF_LAST_T = TW'(TICKS / 2 - 1);
    localparam logic [TW-1:0] SAMPLE_T    = TW'(TICKS - PHASES - 1);

    cyc_kind_e kind_nx;
    logic      half_start;

    assign req_ack    = req_valid && cyc_last && !core_rst;
    assign half_start = cyc_last || (tick == HALF_LAST_T);

    // State register
    always_ff @(posedge clk) begin
        if (core_rst) begin
            kind <= CYC_RESET;
        end else begin
            kind <= kind_nx;
        end
    end

    // Next state: every kind leaves by the same rule at the cycle end
    always_comb begin
        kind_nx = kind;
        if (cyc_last) begin
            unique case (kind)
                CYC_RESET, CYC_CODE, CYC_DREAD, CYC_DWRITE: begin
                    if (req_ack && req_write) begin
                        kind_nx = CYC_DWRITE;      // take_write
                    end else if (req_ack) begin
                        kind_nx = CYC_DREAD;       // take_read
                    end else begin
                        kind_nx = CYC_CODE;        // fetch
                    end
                end
                default: kind_nx = CYC_CODE;
            endcase
        end
    end

    // Fetch address and internal/external choice, once per half
    always_ff @(posedge clk) begin
        if (core_rst) begin
            fetch_addr <= '0;
            fetch_ext  <= 1'b0;
        end else if (half_start) begin
            fetch_addr <= pc;
            fetch_ext  <= !ext_access || (pc > INT_CODE_TOP);
        end
    end

    // Data request capture
    always_ff @(posedge clk) begin
        if (core_rst) begin
            dat_addr  <= '0;
            dat_wide  <= 1'b0;
            dat_wdata <= '0;
        end else if (req_ack) begin
            dat_addr  <= req_addr;
            dat_wide  <= req_wide;
            dat_wdata <= req_wdata;
        end
    end

    // Read byte capture at the last strobe clock
    always_ff @(posedge clk) begin
        if (core_rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (kind == CYC_DREAD) && (tick == SAMPLE_T);
            if ((kind == CYC_DREAD) && (tick == SAMPLE_T)) begin
                rdata <= bus_lo_in;
            end
        end
    end
endmodule

// File: rtl/xbus_pin_decode.sv
`timescale 1ns/1ps
// Pin outputs decoded from the cycle kind and the clock offset.
module xbus_pin_decode
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TICKS  = 12,
    parameter int PHASES = 2,
    localparam int TW   = $clog2(TICKS),
    localparam int HI_W = ADDR_W - DATA_W
) (
    input  cyc_kind_e         kind,
    input  logic [TW-1:0]     tick,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ext,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic              dat_wide,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic [DATA_W-1:0] p2_latch,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] bus_lo_out,
    output logic              bus_lo_oe,
    output logic [HI_W-1:0]   bus_hi
);
    localparam logic [TW-1:0] HALF_T    = TW'(TICKS / 2);
    localparam logic [TW-1:0] PH_T      = TW'(PHASES);
    localparam logic [TW-1:0] STB_FIRST = TW'(2 * PHASES);
    localparam logic [TW-1:0] STB_LAST  = TW'(TICKS - PHASES - 1);

    logic [TW-1:0] hpos;
    logic          strobe_win;

    assign hpos       = (tick >= HALF_T) ? (tick - HALF_T) : tick;
    assign strobe_win = (tick >= STB_FIRST) && (tick <= STB_LAST);

    always_comb begin
        ale        = 1'b0;
        psen_n     = 1'b1;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        bus_lo_out = '0;
        bus_lo_oe  = 1'b0;
        bus_hi     = p2_latch;
        unique case (kind)
            CYC_RESET: begin
            end
            CYC_CODE: begin
                ale        = (hpos < PH_T);
                psen_n     = !(fetch_ext && (hpos > PH_T));
                bus_lo_oe  = fetch_ext && (hpos <= PH_T);
                bus_lo_out = fetch_addr[DATA_W-1:0];
                bus_hi     = fetch_ext ? fetch_addr[ADDR_W-1:DATA_W] : p2_latch;
            end
            CYC_DREAD, CYC_DWRITE: begin
                ale        = (tick < PH_T);
                rd_n       = !((kind == CYC_DREAD) && strobe_win);
                wr_n       = !((kind == CYC_DWRITE) && strobe_win);
                bus_lo_oe  = (kind == CYC_DWRITE) || (tick <= PH_T);
                bus_lo_out = (tick <= PH_T) ? dat_addr[DATA_W-1:0] : dat_wdata;
                bus_hi     = dat_wide ? dat_addr[ADDR_W-1:DATA_W] : p2_latch;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/xbus_sequencer.sv
`timescale 1ns/1ps
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int PHASES        = 2,
    parameter int STATES        = 6,
    parameter int RESET_CYCLES  = 2,
    parameter logic [ADDR_W-1:0] INT_CODE_TOP = 16'h0FFF
) (
    input  logic                 clk,
    input  logic                 rst_in,
    input  logic [ADDR_W-1:0]    pc,
    input  logic                 ext_access,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ack,
    input  logic [DATA_W-1:0]    p2_latch,
    input  logic [DATA_W-1:0]    bus_lo_in,
    output logic [DATA_W-1:0]    bus_lo_out,
    output logic                 bus_lo_oe,
    output logic [ADDR_W-DATA_W-1:0] bus_hi,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_valid,
    output logic                 core_rst
);
    localparam int TICKS = STATES * PHASES;
    localparam int TW    = $clog2(TICKS);

    logic [TW-1:0]     tick;
    logic              cyc_last;
    cyc_kind_e         kind;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ext;
    logic [ADDR_W-1:0] dat_addr;
    logic              dat_wide;
    logic [DATA_W-1:0] dat_wdata;

    xbus_rst_filter #(.HOLD_CLKS(RESET_CYCLES * TICKS)) u_rst (
        .clk      (clk),
        .rst_in   (rst_in),
        .core_rst (core_rst)
    );

    xbus_timebase #(.TICKS(TICKS)) u_time (
        .clk      (clk),
        .core_rst (core_rst),
        .tick     (tick),
        .cyc_last (cyc_last)
    );

    xbus_cycle_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICKS(TICKS),
        .PHASES(PHASES), .INT_CODE_TOP(INT_CODE_TOP)
    ) u_fsm (
        .clk         (clk),
        .core_rst    (core_rst),
        .tick        (tick),
        .cyc_last    (cyc_last),
        .pc          (pc),
        .ext_access  (ext_access),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_wide    (req_wide),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_lo_in   (bus_lo_in),
        .kind        (kind),
        .fetch_addr  (fetch_addr),
        .fetch_ext   (fetch_ext),
        .dat_addr    (dat_addr),
        .dat_wide    (dat_wide),
        .dat_wdata   (dat_wdata),
        .req_ack     (req_ack),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    xbus_pin_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICKS(TICKS), .PHASES(PHASES)
    ) u_pins (
        .kind       (kind),
        .tick       (tick),
        .fetch_addr (fetch_addr),
        .fetch_ext  (fetch_ext),
        .dat_addr   (dat_addr),
        .dat_wide   (dat_wide),
        .dat_wdata  (dat_wdata),
        .p2_latch   (p2_latch),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_lo_out (bus_lo_out),
        .bus_lo_oe  (bus_lo_oe),
        .bus_hi     (bus_hi)
    );
endmodule

// File: rtl/xbus_checker.sv
`timescale 1ns/1ps
module xbus_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_in,
    input logic              core_rst,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              bus_lo_oe,
    input logic [DATA_W-1:0] bus_lo_out,
    input logic              rdata_valid,
    input logic              req_ack
);
    AST_ALE_TWO_CLOCKS: assert property (@(posedge clk) disable iff (core_rst)
        $rose(ale) |=> ale);                                              // R1
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (core_rst)
        ale |-> (psen_n && rd_n && wr_n));                                // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (core_rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);                        // R3
    AST_RD_RELEASES_BUS: assert property (@(posedge clk) disable iff (core_rst)
        !rd_n |-> !bus_lo_oe);                                            // R7
    AST_RDATA_PULSE: assert property (@(posedge clk) disable iff (core_rst)
        rdata_valid |=> !rdata_valid);                                    // R7
    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (core_rst)
        (!wr_n && $past(!wr_n)) |-> (bus_lo_oe && $stable(bus_lo_out)));  // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (core_rst)
        req_ack |=> !req_ack);                                            // R9
    AST_RST_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_in)
        $rose(core_rst) |-> $past(rst_in));                               // R10
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_in)
        $past(core_rst) |-> (!ale && psen_n && rd_n && wr_n && !bus_lo_oe)); // R11
endmodule

bind xbus_sequencer xbus_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_in      (rst_in),
    .core_rst    (core_rst),
    .ale         (ale),
    .psen_n      (psen_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .bus_lo_oe   (bus_lo_oe),
    .bus_lo_out  (bus_lo_out),
    .rdata_valid (rdata_valid),
    .req_ack     (req_ack)
);

// File: tb/tb_xbus_sequencer.sv
`timescale 1ns/1ps
module tb_xbus_sequencer;
    typedef struct packed {
        logic [1:0]  kind;   // 0 code, 1 read, 2 write
        logic        ea;
        logic [15:0] pc;
        logic        wide;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  p2;
        logic [7:0]  rb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 16'h0100, 1'b0, 16'h0000, 8'h00, 8'h3E, 8'h00}, // internal pair
        '{2'd0, 1'b0, 16'h0100, 1'b0, 16'h0000, 8'h00, 8'h3E, 8'h00}, // forced external
        '{2'd0, 1'b1, 16'h0FFF, 1'b0, 16'h0000, 8'h00, 8'hC1, 8'h00}, // straddles 0FFF
        '{2'd0, 1'b1, 16'h2345, 1'b0, 16'h0000, 8'h00, 8'h10, 8'h00}, // high external
        '{2'd1, 1'b1, 16'h0000, 1'b1, 16'h8A5C, 8'h00, 8'h77, 8'h3C}, // wide read
        '{2'd1, 1'b1, 16'h0000, 1'b0, 16'h0042, 8'h00, 8'hE1, 8'h96}, // narrow read
        '{2'd2, 1'b1, 16'h0000, 1'b1, 16'h1234, 8'hA5, 8'h55, 8'h00}, // wide write
        '{2'd2, 1'b1, 16'h0000, 1'b0, 16'h00F0, 8'h5A, 8'h0F, 8'h00}  // narrow write
    };

    logic        clk = 1'b0;
    logic        rst_in = 1'b0;
    logic [15:0] pc = '0;
    logic        ext_access = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  p2_latch = '0;
    logic [7:0]  bus_lo_in = '0;
    logic [7:0]  bus_lo_out;
    logic        bus_lo_oe;
    logic [7:0]  bus_hi;
    logic        ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic        core_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xbus_sequencer dut (
        .clk(clk), .rst_in(rst_in), .pc(pc), .ext_access(ext_access),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .p2_latch(p2_latch), .bus_lo_in(bus_lo_in), .bus_lo_out(bus_lo_out),
        .bus_lo_oe(bus_lo_oe), .bus_hi(bus_hi), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .rdata_valid(rdata_valid),
        .core_rst(core_rst)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pc         = v.pc;
        ext_access = v.ea;
        req_valid  = (v.kind != 2'd0);
        req_write  = (v.kind == 2'd2);
        req_wide   = v.wide;
        req_addr   = v.addr;
        req_wdata  = v.wd;
        p2_latch   = v.p2;
        bus_lo_in  = v.rb;
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, "ale", 32'(ale), 32'd0);
        chk(tag, "psen_n", 32'(psen_n), 32'd1);
        chk(tag, "rd_n", 32'(rd_n), 32'd1);
        chk(tag, "wr_n", 32'(wr_n), 32'd1);
        chk(tag, "bus_lo_oe", 32'(bus_lo_oe), 32'd0);
    endtask

    task automatic check_tick(input vec_t v, input int t);
        int          hp;
        logic [15:0] ah;
        logic        ext;
        logic        isrd, iswr;
        hp   = (t >= 6) ? t - 6 : t;
        ah   = (t >= 6) ? v.pc + 16'd1 : v.pc;
        ext  = !v.ea || (ah > 16'h0FFF);
        isrd = (v.kind == 2'd1);
        iswr = (v.kind == 2'd2);
        if (v.kind == 2'd0) begin
            chk("R1", "code ale", 32'(ale), 32'(hp < 2));
            chk("R3", "code psen_n", 32'(psen_n), 32'(!(ext && hp > 2)));
            chk("R3", "code rd_n/wr_n", 32'({rd_n, wr_n}), 32'd3);
            chk("R5", "code oe", 32'(bus_lo_oe), 32'(ext && hp <= 2));
            if (ext && hp <= 2) chk("R5", "code lo addr", 32'(bus_lo_out), 32'(ah[7:0]));
            // R4: external choice shows on the high bus as well
            chk("R6", "code hi", 32'(bus_hi), 32'(ext ? ah[15:8] : v.p2));
        end else begin
            chk("R2", "data ale", 32'(ale), 32'(t < 2));
            chk("R2", "data psen_n", 32'(psen_n), 32'd1);
            chk("R7", "rd_n", 32'(rd_n), 32'(!(isrd && t >= 4 && t <= 9)));
            chk("R8", "wr_n", 32'(wr_n), 32'(!(iswr && t >= 4 && t <= 9)));
            chk("R8", "data oe", 32'(bus_lo_oe), 32'(iswr || t <= 2));
            if (t <= 2) chk("R5", "data lo addr", 32'(bus_lo_out), 32'(v.addr[7:0]));
            else if (iswr) chk("R8", "write byte", 32'(bus_lo_out), 32'(v.wd));
            chk("R6", "data hi", 32'(bus_hi), 32'(v.wide ? v.addr[15:8] : v.p2));
        end
        chk("R7", "rdata_valid", 32'(rdata_valid), 32'(isrd && t == 10));
        if (isrd && t == 10) chk("R7", "rdata", 32'(rdata), 32'(v.rb));
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_in = 1'b1;
        repeat (23) @(negedge clk);
        chk("R10", "core_rst after 23", 32'(core_rst), 32'd0);
        @(negedge clk);
        chk("R10", "core_rst after 24", 32'(core_rst), 32'd1);
        @(negedge clk);
        check_quiet("R11");
        apply(VEC[0]);
        rst_in = 1'b0;
        #1;
        for (int i = 0; i < NV; i++) begin
            // R9: request taken at offset 11
            chk("R9", "req_ack", 32'(req_ack), 32'(VEC[i].kind != 2'd0));
            for (int t = 0; t < 12; t++) begin
                @(negedge clk);
                check_tick(VEC[i], t);
                if (t == 0) req_valid = 1'b0;
                if (t == 0) chk("R9", "no ack mid-cycle", 32'(req_ack), 32'd0);
                if (t == 5) pc = VEC[i].pc + 16'd1;
                if (t == 11) begin
                    if (i + 1 < NV) apply(VEC[i + 1]);
                    else begin
                        req_valid = 1'b0;
                        ext_access = 1'b1;
                        pc = '0;
                    end
                    #1;
                end
            end
        end
        // R10: short reset pulse is ignored
        begin
            int   rises;
            logic prev;
            rises = 0;
            prev = ale;
            rst_in = 1'b1;
            repeat (23) begin
                @(negedge clk);
                if (ale && !prev) rises++;
                prev = ale;
            end
            chk("R10", "short pulse core_rst", 32'(core_rst), 32'd0);
            chk("R10", "ale kept running", 32'(rises >= 3), 32'd1);
            rst_in = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_in = 1'b1;
        repeat (25) @(negedge clk);
        chk("R10", "second reset", 32'(core_rst), 32'd1);
        check_quiet("R11");
        rst_in = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule